// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. Its clock runs at sixteen times the bit rate, so every bit on the line lasts a fixed number of clock cycles. A frame opens with a low start bit. It then sends 5, 6, 7 or 8 data bits, least significant first. An optional parity bit, even or odd, may follow. The frame closes with one, one and a half, or two high stop bits. The serial line rests high between frames.

Characters go into a one-entry holding buffer through an active-low load strobe. When the shifter is free, the buffer hands its character over on a bit boundary, so the next character can be written while the current one is still going out. Two status outputs report buffer-empty and shifter-empty separately. The frame format is set by level inputs. Those inputs are sampled when a character enters the shifter, so they can change between frames at run time.

Top module: `uart_tx_fmt`

## Requirements
- R1: One bit period is OVERSAMPLE clock cycles (16 by default). The line `txd` is high at rest, and each frame starts with one low bit period.
- R2: `len_code` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits leave bit 0 first, and bits of `tx_data` above the selected length are not sent.
- R3: With `par_off` low, one parity bit follows the data. When `par_even` is high, the data bits plus the parity bit hold an even count of ones; when it is low, they hold an odd count. With `par_off` high, the stop bits follow the data directly.
- R4: With `stop_two` low, the line stays high for OVERSAMPLE cycles after the data and parity bits. With `stop_two` high, it stays high for 2*OVERSAMPLE cycles, or for 1.5*OVERSAMPLE cycles when `len_code` is 2'b00.
- R5: When `load_n` is low at a rising clock edge, `tx_data` is written into the buffer, and `buf_empty` is low from the next cycle. A write to a buffer that already holds a character replaces that character.
- R6: A held character moves into the shifter at the first bit boundary at which the shifter is idle or is ending its last stop cycle. At that edge `buf_empty` goes high and `txd` goes low. Consecutive frames therefore follow each other with no idle gap when their length is a whole number of bit periods.
- R7: `shift_empty` falls at the transfer edge and rises at the edge that ends the last stop cycle, unless another character is transferred at that same edge.
- R8: The format inputs are sampled at the transfer edge. Changing them during a frame does not alter that frame.
- R9: Driving `rst_n` low at once sets `txd` high, `buf_empty` high and `shift_empty` high. Release passes through a two-stage synchroniser, and no character is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Asynchronous active-low master reset |
| load_n | input | 1 | Active-low buffer write strobe |
| tx_data | input | 8 | Character to be written into the buffer |
| len_code | input | 2 | Data length select (00=5 … 11=8 bits) |
| stop_two | input | 1 | High selects two stop bits (1.5 in 5-bit mode) |
| par_even | input | 1 | High selects even parity, low selects odd |
| par_off | input | 1 | High suppresses the parity bit |
| txd | output | 1 | Serial output, high at rest |
| buf_empty | output | 1 | High when the buffer holds no pending character |
| shift_empty | output | 1 | High when no frame is being sent |

## Verification
The bench builds the block with the default OVERSAMPLE of 16. With that value the one-and-a-half stop period comes to exactly 24 cycles, and a 5-bit frame then ends halfway through a bit period, so the wait for the next boundary becomes visible. All four lengths, both parity senses, parity off and all three stop lengths are measured as exact cycle counts to the rise of `shift_empty`. Directed runs cover a gap-free pair of frames, an overwrite of a full buffer, a format change during a frame, and a reset in the middle of a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_W  = 8;
  localparam int LEN_MIN = 5;
  localparam int BODY_W  = 4;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_BITS,
    TX_STOP
  } tx_state_e;

  function automatic logic [BODY_W-1:0] char_bits(input logic [1:0] code);
    return BODY_W'(LEN_MIN) + {2'b00, code};
  endfunction

endpackage

// File: rtl/uart_tx_phase.sv
module uart_tx_phase #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_end
);

  localparam int PH_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  logic [PH_W-1:0] phase_q, phase_d;

  assign bit_end = (phase_q == PH_LAST);

  always_comb begin
    if (bit_end) phase_d = '0;
    else         phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);

  logic              full_q, full_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              data_en;

  assign data_en = !wr_n;

  always_comb begin
    full_d = full_q;
    if (take)  full_d = 1'b0;
    if (!wr_n) full_d = 1'b1;
    data_d = data_en ? wr_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign full = full_q;
  assign data = data_q;

  // R5
  write_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> full_q);

  // R6
  take_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic              buf_full,
  input  logic [CHAR_W-1:0] buf_data,
  input  logic [1:0]        len_code,
  input  logic              stop_two,
  input  logic              par_even,
  input  logic              par_off,
  output logic              take,
  output logic              txd,
  output logic              idle
);

  localparam int STOP_W = $clog2(2 * OVERSAMPLE + 1);
  localparam logic [STOP_W-1:0] STOP_ONE  = STOP_W'(OVERSAMPLE);
  localparam logic [STOP_W-1:0] STOP_HALF = STOP_W'(OVERSAMPLE + OVERSAMPLE / 2);
  localparam logic [STOP_W-1:0] STOP_TWO  = STOP_W'(2 * OVERSAMPLE);

  tx_state_e          state_q, state_d;
  logic [CHAR_W:0]    sh_q, sh_d;
  logic [BODY_W-1:0]  left_q, left_d;
  logic [STOP_W-1:0]  stop_q, stop_d;
  logic [STOP_W-1:0]  stop_len_q, stop_len_d;
  logic               txd_q, txd_d;

  logic [BODY_W-1:0]  nbits;
  logic [BODY_W-1:0]  body;
  logic [CHAR_W-1:0]  mask;
  logic [CHAR_W-1:0]  masked;
  logic               par_bit;
  logic [CHAR_W:0]    word;
  logic [STOP_W-1:0]  stop_pick;
  logic               shifter_free;

  // frame assembly from the buffer and the live format inputs
  always_comb begin
    nbits     = char_bits(len_code);
    body      = nbits + (par_off ? BODY_W'(0) : BODY_W'(1));
    mask      = ~({CHAR_W{1'b1}} << nbits);
    masked    = buf_data & mask;
    par_bit   = (^masked) ^ !par_even;
    word      = {1'b0, masked} | ({{CHAR_W{1'b0}}, par_bit & !par_off} << nbits);
    if (!stop_two)              stop_pick = STOP_ONE;
    else if (len_code == 2'b00) stop_pick = STOP_HALF;
    else                        stop_pick = STOP_TWO;
  end

  assign shifter_free = (state_q == TX_IDLE) ||
                        ((state_q == TX_STOP) && (stop_q == '0));
  assign take = bit_end && buf_full && shifter_free;

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    left_d     = left_q;
    stop_d     = stop_q;
    stop_len_d = stop_len_q;
    txd_d      = txd_q;
    case (state_q)
      TX_IDLE: txd_d = 1'b1;
      TX_START: begin
        if (bit_end) begin
          state_d = TX_BITS;
          txd_d   = sh_q[0];
          sh_d    = sh_q >> 1;
          left_d  = left_q - BODY_W'(1);
        end
      end
      TX_BITS: begin
        if (bit_end) begin
          if (left_q != '0) begin
            txd_d  = sh_q[0];
            sh_d   = sh_q >> 1;
            left_d = left_q - BODY_W'(1);
          end else begin
            state_d = TX_STOP;
            txd_d   = 1'b1;
            stop_d  = stop_len_q - STOP_W'(1);
          end
        end
      end
      TX_STOP: begin
        if (stop_q == '0) state_d = TX_IDLE;
        else              stop_d  = stop_q - STOP_W'(1);
      end
      default: state_d = TX_IDLE;
    endcase
    if (take) begin
      state_d    = TX_START;
      txd_d      = 1'b0;
      sh_d       = word;
      left_d     = body;
      stop_len_d = stop_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      stop_q     <= '0;
      stop_len_q <= STOP_ONE;
      txd_q      <= 1'b1;
    end else begin
      state_q    <= state_d;
      sh_q       <= sh_d;
      left_q     <= left_d;
      stop_q     <= stop_d;
      stop_len_q <= stop_len_d;
      txd_q      <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign idle = (state_q == TX_IDLE);

  // R1
  bits_hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_BITS && $past(state_q) == TX_BITS && !$past(bit_end)) |-> $stable(txd_q));

  // R4
  stop_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_STOP) |-> txd_q);

  // R6
  start_from_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_START && $past(state_q) != TX_START) |-> ($past(bit_end) && $past(buf_full)));

  // R7
  empty_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> ($past(state_q) == TX_STOP));

endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic [1:0]        len_code,
  input  logic              stop_two,
  input  logic              par_even,
  input  logic              par_off,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_empty
);

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              bit_end;
  logic              take;
  logic              buf_full;
  logic [CHAR_W-1:0] buf_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  uart_tx_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_s),
    .bit_end (bit_end)
  );

  uart_tx_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_n    (load_n),
    .wr_data (tx_data),
    .take    (take),
    .full    (buf_full),
    .data    (buf_data)
  );

  uart_tx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s),
    .bit_end  (bit_end),
    .buf_full (buf_full),
    .buf_data (buf_data),
    .len_code (len_code),
    .stop_two (stop_two),
    .par_even (par_even),
    .par_off  (par_off),
    .take     (take),
    .txd      (txd),
    .idle     (shift_empty)
  );

  assign buf_empty = !buf_full;

endmodule

// File: tb/tb_uart_tx_fmt.sv
module tb_uart_tx_fmt;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic [1:0] len_code = 2'b11;
  logic       stop_two = 1'b0;
  logic       par_even = 1'b1;
  logic       par_off = 1'b0;
  logic       txd, buf_empty, shift_empty;

  int checks = 0;
  int errors = 0;
  int idx = 0;

  always #4 clk = ~clk;

  uart_tx_fmt dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .tx_data(tx_data),
    .len_code(len_code), .stop_two(stop_two), .par_even(par_even),
    .par_off(par_off), .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty)
  );

  typedef struct packed {
    logic [7:0] din;
    logic [1:0] len;
    logic       two;
    logic       even;
    logic       off;
    logic [7:0] exp_data;
    logic       exp_par;
    logic [8:0] exp_ticks;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'hA5, 2'b11, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 9'd176},
    '{8'h3C, 2'b00, 1'b1, 1'b0, 1'b0, 8'h1C, 1'b0, 9'd136},
    '{8'hFF, 2'b01, 1'b1, 1'b1, 1'b1, 8'h3F, 1'b0, 9'd144},
    '{8'h81, 2'b10, 1'b0, 1'b1, 1'b0, 8'h01, 1'b1, 9'd160},
    '{8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 9'd192},
    '{8'h5A, 2'b00, 1'b0, 1'b1, 1'b0, 8'h1A, 1'b1, 9'd128},
    '{8'h96, 2'b10, 1'b0, 1'b0, 1'b1, 8'h16, 1'b0, 9'd144}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
  endtask

  task automatic run_vector(input vec_t v);
    int nb, body, wait_n;
    logic [7:0] got;
    logic gp;
    bit stop_ok;
    nb = 5 + int'(v.len);
    body = nb + (v.off ? 0 : 1);
    got = 8'h00;
    gp = 1'b0;
    stop_ok = 1'b1;
    wait_n = 0;
    tx_data = v.din; len_code = v.len; stop_two = v.two;
    par_even = v.even; par_off = v.off;
    load_n = 1'b0;
    step();
    load_n = 1'b1;
    check(buf_empty == 1'b0, "R5", "buf_empty after write", int'(buf_empty), 0);
    while (txd !== 1'b0 && wait_n < 40) begin
      step();
      wait_n++;
    end
    idx = 0;
    check(wait_n <= 16, "R6", "cycles to transfer", wait_n, 16);
    check(buf_empty == 1'b1 && shift_empty == 1'b0, "R6", "status at transfer",
          int'({buf_empty, shift_empty}), 2);
    while (idx < int'(v.exp_ticks)) begin
      step();
      if (idx == 8) check(txd == 1'b0, "R1", "start bit", int'(txd), 0);
      if (idx % 16 == 8 && idx / 16 >= 1 && idx / 16 <= nb) got[idx / 16 - 1] = txd;
      if (!v.off && idx == 16 * (1 + nb) + 8) gp = txd;
      if (idx >= 16 * (1 + body) && txd !== 1'b1) stop_ok = 1'b0;
      if (idx == int'(v.exp_ticks) - 1)
        check(shift_empty == 1'b0, "R7", "shift_empty before end", int'(shift_empty), 0);
    end
    check(shift_empty == 1'b1, "R7", "shift_empty at frame end", int'(shift_empty), 1);
    check(got == v.exp_data, "R2", "data bits", int'(got), int'(v.exp_data));
    if (!v.off) check(gp == v.exp_par, "R3", "parity bit", int'(gp), int'(v.exp_par));
    check(stop_ok, "R4", "stop period high", int'(stop_ok), 1);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got_a, got_c;
    int wait_n;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && buf_empty == 1'b1 && shift_empty == 1'b1, "R9",
          "outputs in reset", int'({txd, buf_empty, shift_empty}), 7);
    rst_n = 1'b1;
    repeat (4) step();
    check(txd == 1'b1 && buf_empty == 1'b1 && shift_empty == 1'b1, "R1",
          "idle after release", int'({txd, buf_empty, shift_empty}), 7);

    foreach (VECS[i]) run_vector(VECS[i]);

    // R5 overwrite, R6 gap-free, R8 format held during frame
    len_code = 2'b11; stop_two = 1'b0; par_off = 1'b1; par_even = 1'b1;
    tx_data = 8'h11; load_n = 1'b0;
    step();
    load_n = 1'b1;
    wait_n = 0;
    while (txd !== 1'b0 && wait_n < 40) begin
      step();
      wait_n++;
    end
    idx = 0;
    tx_data = 8'h3C; load_n = 1'b0;
    step();
    tx_data = 8'hE7;
    step();
    load_n = 1'b1; len_code = 2'b00;
    got_a = 8'h00;
    while (idx < 160) begin
      step();
      if (idx % 16 == 8 && idx / 16 >= 1 && idx / 16 <= 8) got_a[idx / 16 - 1] = txd;
    end
    check(got_a == 8'h11, "R8", "frame kept its sampled length", int'(got_a), 'h11);
    check(txd == 1'b0, "R6", "next start with no gap", int'(txd), 0);
    check(shift_empty == 1'b0 && buf_empty == 1'b1, "R6", "status at back-to-back transfer",
          int'({shift_empty, buf_empty}), 1);
    got_c = 8'h00;
    while (idx < 272) begin
      step();
      if ((idx - 160) % 16 == 8 && (idx - 160) / 16 >= 1 && (idx - 160) / 16 <= 5)
        got_c[(idx - 160) / 16 - 1] = txd;
      if (idx == 271)
        check(shift_empty == 1'b0, "R7", "shift_empty before second end", int'(shift_empty), 0);
    end
    check(shift_empty == 1'b1, "R7", "shift_empty after second frame", int'(shift_empty), 1);
    check(got_c == 8'h07, "R5", "overwritten character sent", int'(got_c), 'h07);

    // R9 reset in the middle of a frame
    len_code = 2'b11; par_off = 1'b0; tx_data = 8'h00; load_n = 1'b0;
    step();
    load_n = 1'b1;
    wait_n = 0;
    while (txd !== 1'b0 && wait_n < 40) begin
      step();
      wait_n++;
    end
    repeat (20) step();
    rst_n = 1'b0;
    #1;
    check(txd == 1'b1 && buf_empty == 1'b1 && shift_empty == 1'b1, "R9",
          "async reset mid-frame", int'({txd, buf_empty, shift_empty}), 7);
    step();
    rst_n = 1'b1;
    wait_n = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (txd !== 1'b1 || shift_empty !== 1'b1) wait_n++;
    end
    check(wait_n == 0, "R9", "no pending character after reset", wait_n, 0);
    run_vector(VECS[0]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule